// File: doc/BRIEF.md
# Maskable Interrupt Status Register with Read-Triggered Clear

This block gathers eight interrupt source events into a sticky status register and drives a single active-high interrupt request pin. A mask register, written by the host over the serial-clock side, decides which of the set status bits may raise the pin. A masked source still records its event, so the host can see it when it reads the register.

A host read arms a clear of the whole register. While the system oscillator is running, the read indication crosses into the oscillator domain through a synchronizer, and the clear follows a few oscillator cycles later. When the oscillator is stopped, as in a low-power wake-detect state, the `osc_run` flag routes the register onto the serial clock instead. The clear then lands on the very next serial-clock rising edge after the read. That edge may be a dummy edge at the end of the read or the first edge of the following transaction.

The read port and the mask write port are plain strobes sampled on `ser_clk`. They are always accepted, so they have no valid/ready pair and no back-pressure. Source events are one-cycle pulses sampled on whichever clock currently owns the register.

Top module: `irq_readclear_ctl`

## Requirements
- R1: A high bit i on `src_evt` at a register-clock edge sets status bit i. The bit then stays set until a clear is applied.
- R2: `irq_o` is high exactly when at least one status bit is set whose mask bit is 0.
- R3: A source whose mask bit is 1 still sets its status bit but does not raise `irq_o`. Clearing that mask bit later raises `irq_o` at once if the status bit is still set.
- R4: `rd_data` always shows the status register, bit i for source i. A read is `rd_req` high at a `ser_clk` rising edge.
- R5: With `osc_run` = 1, the read leaves the status unchanged at the read edge. Status and `irq_o` are cleared within three `sys_clk` rising edges after the read edge.
- R6: With `osc_run` = 0, the read edge itself does not clear the status. The first `ser_clk` rising edge after the read edge clears it.
- R7: A source event sampled on the same edge as the clear survives: after that edge the status equals that event vector.
- R8: `mask_we` high at a `ser_clk` rising edge loads `mask_wdata` into the mask, with bit i masking source i.
- R9: Asserting `rst_n` low clears the status register, the mask register and any pending clear, and forces `irq_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset |
| sys_clk | input | 1 | System oscillator clock, may be stopped |
| ser_clk | input | 1 | Serial interface clock |
| osc_run | input | 1 | 1 = oscillator running; selects the clock that owns the register |
| src_evt | input | 8 | Source event pulses, one bit per source |
| mask_we | input | 1 | Mask write strobe (ser_clk) |
| mask_wdata | input | 8 | New mask value, 1 = masked |
| rd_req | input | 1 | Status read strobe (ser_clk) |
| rd_data | output | 8 | Current status register |
| irq_o | output | 1 | Active-high interrupt request |

## Verification
The bench checks that the clear does not take effect at the read edge itself in either clock mode. A design that cleared early would wipe events the host never saw. In oscillator-stopped mode it checks that the very next serial edge clears the register; a design that waited on the stalled synchronizer would never clear. It drives an event onto the clearing edge, which exposes a design that lets the clear win and loses the event. It also checks that a masked-but-set bit raises the pin as soon as it is unmasked, and that reset releases the mask.

// File: rtl/irq_pkg.sv
package irq_pkg;
  parameter int unsigned N_SRC       = 8;
  parameter int unsigned SYNC_STAGES = 2;
  typedef logic [N_SRC-1:0] src_vec_t;
endpackage

// File: rtl/irq_clk_sel.sv
module irq_clk_sel (
  input  logic sys_clk,
  input  logic ser_clk,
  input  logic osc_run,
  output logic reg_clk
);
  // osc_run may only change while both clocks are low
  assign reg_clk = osc_run ? sys_clk : ser_clk;
endmodule

// File: rtl/irq_host_if.sv
module irq_host_if
  import irq_pkg::*;
(
  input  logic     ser_clk,
  input  logic     rst_n,
  input  logic     mask_we,
  input  src_vec_t mask_wdata,
  input  logic     rd_req,
  output src_vec_t mask_q,
  output logic     rd_tog
);
  always_ff @(posedge ser_clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      rd_tog <= 1'b0;
    end else begin
      if (mask_we) mask_q <= mask_wdata;
      if (rd_req)  rd_tog <= ~rd_tog;
    end
  end
endmodule

// File: rtl/irq_clr_ctrl.sv
module irq_clr_ctrl
  import irq_pkg::*;
(
  input  logic reg_clk,
  input  logic rst_n,
  input  logic osc_run,
  input  logic rd_tog,
  output logic clr_fire
);
  localparam int unsigned TOP = SYNC_STAGES - 1;

  logic [TOP:0] sync_q;
  logic         ack_q;
  logic         seen;

  // oscillator running: cross through the synchronizer;
  // stopped: the register shares ser_clk, use the toggle directly
  assign seen     = osc_run ? sync_q[TOP] : rd_tog;
  assign clr_fire = seen ^ ack_q;

  always_ff @(posedge reg_clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      ack_q  <= 1'b0;
    end else begin
      if (osc_run) sync_q <= {sync_q[TOP-1:0], rd_tog};
      else         sync_q <= {SYNC_STAGES{rd_tog}};
      if (clr_fire) ack_q <= seen;
    end
  end

  // R5: with the oscillator running, one read produces one clear
  a_r5_single_clear: assert property (@(posedge reg_clk) disable iff (!rst_n)
    (osc_run && clr_fire) |=> !clr_fire);
endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg
  import irq_pkg::*;
(
  input  logic     reg_clk,
  input  logic     rst_n,
  input  logic     clr_fire,
  input  src_vec_t src_evt,
  output src_vec_t status_q
);
  always_ff @(posedge reg_clk or negedge rst_n) begin
    if (!rst_n)        status_q <= '0;
    else if (clr_fire) status_q <= src_evt;
    else               status_q <= status_q | src_evt;
  end

  // R1: bits stay set without a clear
  a_r1_sticky: assert property (@(posedge reg_clk) disable iff (!rst_n)
    !clr_fire |=> ((status_q & $past(status_q)) == $past(status_q)));
  // R1: an event always lands in the register
  a_r1_event_lands: assert property (@(posedge reg_clk) disable iff (!rst_n)
    (src_evt != '0) |=> ((status_q & $past(src_evt)) == $past(src_evt)));
  // R7: clear keeps exactly the coincident events
  a_r7_clear_keeps_evt: assert property (@(posedge reg_clk) disable iff (!rst_n)
    clr_fire |=> (status_q == $past(src_evt)));
endmodule

// File: rtl/irq_readclear_ctl.sv
module irq_readclear_ctl
  import irq_pkg::*;
(
  input  logic       rst_n,
  input  logic       sys_clk,
  input  logic       ser_clk,
  input  logic       osc_run,
  input  logic [7:0] src_evt,
  input  logic       mask_we,
  input  logic [7:0] mask_wdata,
  input  logic       rd_req,
  output logic [7:0] rd_data,
  output logic       irq_o
);
  logic     reg_clk;
  logic     rd_tog;
  logic     clr_fire;
  src_vec_t mask_q;
  src_vec_t status_q;

  irq_clk_sel u_clk_sel (
    .sys_clk (sys_clk),
    .ser_clk (ser_clk),
    .osc_run (osc_run),
    .reg_clk (reg_clk)
  );

  irq_host_if u_host (
    .ser_clk    (ser_clk),
    .rst_n      (rst_n),
    .mask_we    (mask_we),
    .mask_wdata (mask_wdata),
    .rd_req     (rd_req),
    .mask_q     (mask_q),
    .rd_tog     (rd_tog)
  );

  irq_clr_ctrl u_clr (
    .reg_clk  (reg_clk),
    .rst_n    (rst_n),
    .osc_run  (osc_run),
    .rd_tog   (rd_tog),
    .clr_fire (clr_fire)
  );

  irq_status_reg u_stat (
    .reg_clk  (reg_clk),
    .rst_n    (rst_n),
    .clr_fire (clr_fire),
    .src_evt  (src_evt),
    .status_q (status_q)
  );

  assign rd_data = status_q;
  assign irq_o   = |(status_q & ~mask_q);

  // R2: a clear with no coincident event and no later event drops the pin
  a_r2_irq_drops: assert property (@(posedge reg_clk) disable iff (!rst_n)
    (clr_fire && src_evt == '0) |=> (!irq_o || $past(src_evt) != '0 || src_evt != '0));
  // R9: nothing is pending right after reset
  a_r9_reset_quiet: assert property (@(posedge reg_clk) disable iff (!rst_n)
    ($rose(rst_n)) |-> (status_q == '0));
endmodule

// File: tb/irq_readclear_ctl_tb.sv
module irq_readclear_ctl_tb;
  logic       rst_n = 1'b0;
  logic       sys_clk = 1'b0;
  logic       ser_clk = 1'b0;
  logic       sys_en = 1'b1;
  logic       osc_run = 1'b1;
  logic [7:0] src_evt = '0;
  logic       mask_we = 1'b0;
  logic [7:0] mask_wdata = '0;
  logic       rd_req = 1'b0;
  logic [7:0] rd_data;
  logic       irq_o;
  int         checks = 0;
  int         errors = 0;
  bit         done = 1'b0;

  irq_readclear_ctl u_dut (
    .rst_n(rst_n), .sys_clk(sys_clk), .ser_clk(ser_clk), .osc_run(osc_run),
    .src_evt(src_evt), .mask_we(mask_we), .mask_wdata(mask_wdata),
    .rd_req(rd_req), .rd_data(rd_data), .irq_o(irq_o)
  );

  initial forever #2 sys_clk = sys_en ? ~sys_clk : 1'b0;

  task automatic chk(string req, logic [8:0] act, logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic ser_edge();
    #5 ser_clk = 1'b1;
    #5 ser_clk = 1'b0;
    #5;
  endtask

  task automatic sys_evt(logic [7:0] v);
    @(negedge sys_clk) src_evt = v;
    @(negedge sys_clk) src_evt = '0;
  endtask

  task automatic write_mask(logic [7:0] m);
    mask_we = 1'b1; mask_wdata = m;
    ser_edge();
    mask_we = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    #13 rst_n = 1'b1;
    #7;
  endtask

  task automatic t_reset_state();
    chk("R9 reset status", {1'b0, rd_data}, 9'h000);
    chk("R9 reset irq", {8'h0, irq_o}, 9'h000);
  endtask

  task automatic t_set_and_irq();
    sys_evt(8'h08);
    chk("R1 event sets bit", {1'b0, rd_data}, 9'h008);
    chk("R2 unmasked raises irq", {8'h0, irq_o}, 9'h001);
    sys_evt(8'h01);
    chk("R1 bits accumulate", {1'b0, rd_data}, 9'h009);
  endtask

  task automatic t_read_clear_osc_on();
    chk("R4 read data", {1'b0, rd_data}, 9'h009);
    rd_req = 1'b1;
    #5 ser_clk = 1'b1;
    #1 chk("R5 not cleared at read edge", {1'b0, rd_data}, 9'h009);
    #4 ser_clk = 1'b0;
    rd_req = 1'b0;
    repeat (4) @(negedge sys_clk);
    chk("R5 cleared on sys clock", {1'b0, rd_data}, 9'h000);
    chk("R5 irq dropped", {8'h0, irq_o}, 9'h000);
  endtask

  task automatic t_mask();
    write_mask(8'h20);
    sys_evt(8'h20);
    chk("R3 masked bit still set", {1'b0, rd_data}, 9'h020);
    chk("R8 masked source no irq", {8'h0, irq_o}, 9'h000);
    write_mask(8'h00);
    #1 chk("R3 unmask raises irq", {8'h0, irq_o}, 9'h001);
  endtask

  task automatic t_osc_off();
    sys_en = 1'b0;
    #10 osc_run = 1'b0;
    #5;
    // clear left over bit 5 with a read plus a dummy edge
    rd_req = 1'b1; ser_edge(); rd_req = 1'b0; ser_edge();
    src_evt = 8'h01; ser_edge(); src_evt = '0;
    chk("R1 event on serial clock", {1'b0, rd_data}, 9'h001);
    rd_req = 1'b1;
    #5 ser_clk = 1'b1;
    #1 chk("R6 not cleared at read edge", {1'b0, rd_data}, 9'h001);
    #4 ser_clk = 1'b0; rd_req = 1'b0;
    #5;
    ser_edge();
    chk("R6 cleared on next serial edge", {1'b0, rd_data}, 9'h000);
    chk("R6 irq dropped", {8'h0, irq_o}, 9'h000);
    src_evt = 8'h04; ser_edge(); src_evt = '0;
    rd_req = 1'b1; ser_edge(); rd_req = 1'b0;
    src_evt = 8'h02; ser_edge(); src_evt = '0;
    chk("R7 coincident event kept", {1'b0, rd_data}, 9'h002);
    osc_run = 1'b1;
    #5 sys_en = 1'b1;
  endtask

  task automatic t_reset_mask();
    write_mask(8'hFF);
    do_reset();
    t_reset_state();
    sys_evt(8'h40);
    chk("R9 mask cleared by reset", {8'h0, irq_o}, 9'h001);
  endtask

  initial begin
    #13 rst_n = 1'b1;
    #7;
    t_reset_state();
    t_set_and_irq();
    t_read_clear_osc_on();
    t_mask();
    t_osc_off();
    t_reset_mask();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule